// File: doc/BRIEF.md
# Tagged Predictor Entry Update Unit

This block holds the tagged tables of a multi-table branch predictor and applies the update that follows branch resolution. Each table entry stores a signed direction counter, a partial tag and an unsigned usefulness counter. Tables are numbered 1 to `NUM_TABLES`, and a higher number means a longer history. Provider number 0 means the base predictor supplied the prediction and no tagged table hit.

On a valid update the block adjusts the usefulness counter of the provider entry. It does this only when the provider and the alternate prediction disagree, moving the counter toward or away from usefulness depending on whether the provider was right.

When an allocate request comes with the update, the block scans the tables with longer history than the provider, starting from the longest. It claims the first entry whose usefulness is zero and seeds it with the new tag and a weak direction counter. The minimum usefulness seen over the candidate entries is reported so that an outside aging policy can act when nothing is free. A combinational read port exposes any entry so that the prediction side can read it.

Top module: `tage_upd_unit`

## Requirements
- R1: After reset every entry of every table reads back direction counter 0, tag 0 and usefulness 0.
- R2: The usefulness counters stay unchanged when `upd_valid` is low, when the provider number is 0, or when `upd_prov_pred` equals `upd_alt_pred`.
- R3: When the provider (1..NUM_TABLES) and alternate disagree and `upd_prov_pred` equals `upd_taken`, the provider entry's usefulness at that table's index rises by one, saturating at 2^U_W-1.
- R4: When the provider and alternate disagree and `upd_prov_pred` differs from `upd_taken`, that usefulness falls by one, saturating at 0.
- R5: Only tables numbered above the provider are allocation candidates; provider 0 makes every table a candidate, provider NUM_TABLES makes none.
- R6: The candidates are scanned from table NUM_TABLES downward. The first one whose usefulness at its index is 0 is claimed, and no other table is written.
- R7: A claimed entry takes the request's tag for that table and a direction counter of 0 when taken or all ones (-1) when not taken. Its usefulness is not written.
- R8: With `upd_alloc` low, or with no candidate at usefulness 0, no tag or direction counter changes.
- R9: `min_u` combinationally equals the smaller of 1 and the lowest usefulness among the candidate entries at the presented indices.
- R10: The read port returns table `rd_table` (1..NUM_TABLES) at `rd_idx` combinationally, and all zeros for any other table number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update request this cycle |
| upd_taken | input | 1 | Resolved branch direction |
| upd_provider | input | clog2(NUM_TABLES+1) | Providing table number, 0 = base predictor |
| upd_prov_pred | input | 1 | Provider's predicted direction |
| upd_alt_pred | input | 1 | Alternate predicted direction |
| upd_alloc | input | 1 | Allocate a new entry |
| upd_idx | input | NUM_TABLES*IDX_W | Per-table index, table t in slice t-1 |
| upd_tag | input | NUM_TABLES*TAG_W | Per-table partial tag, table t in slice t-1 |
| min_u | output | U_W | Minimum candidate usefulness, capped at 1 |
| rd_table | input | clog2(NUM_TABLES+1) | Read port table number |
| rd_idx | input | IDX_W | Read port index |
| rd_ctr | output | CTR_W | Direction counter read |
| rd_tag | output | TAG_W | Tag read |
| rd_u | output | U_W | Usefulness read |

## Verification
The bench drives usefulness into both saturation points and past them. A counter that wraps would read 0 after a fourth increment or 3 after an extra decrement.

It sets up scans where the longest table is busy but shorter ones are free. This exposes a search that starts at the wrong end, claims more than one table, or considers tables at or below the provider. It also re-allocates into the same slot to confirm that usefulness is not written on a claim.

Requests with provider 0 and with provider NUM_TABLES cover the candidate bounds and the `min_u` value of 1 when the candidate set is empty. Agreeing predictions and provider 0 confirm that usefulness is held.

// File: rtl/tage_upd_pkg.sv
package tage_upd_pkg;

   // Largest supported usefulness width.
   localparam int unsigned U_W_MAX = 2;
   // Widest direction counter the seed function covers.
   localparam int unsigned CTR_W_MAX = 16;

   // Weakest counter value toward the resolved direction: 0 or -1.
   function automatic logic [CTR_W_MAX-1:0] weak_seed(input logic taken);
      return taken ? {CTR_W_MAX{1'b0}} : {CTR_W_MAX{1'b1}};
   endfunction

endpackage

// File: rtl/tage_u_ctr.sv
module tage_u_ctr #(
   parameter int unsigned U_W = 2
) (
   input  logic [U_W-1:0] cur,
   input  logic           up,
   output logic [U_W-1:0] nxt
);
   localparam logic [U_W-1:0] U_TOP = {U_W{1'b1}};
   localparam logic [U_W-1:0] U_ONE = U_W'(1);

   generate
      if (U_W == 1) begin : g_single
         // One bit: moving up saturates at 1 and moving down at 0.
         assign nxt = up;
      end else begin : g_multi
         always_comb begin
            if (up) nxt = (cur == U_TOP) ? cur : cur + U_ONE;
            else    nxt = (cur == '0)    ? cur : cur - U_ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/tage_bank.sv
module tage_bank #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 8,
   parameter int unsigned CTR_W = 3,
   parameter int unsigned U_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             u_we,
   input  logic [U_W-1:0]   u_wdata,
   input  logic             a_we,
   input  logic [TAG_W-1:0] a_tag,
   input  logic [CTR_W-1:0] a_ctr,
   output logic [U_W-1:0]   u_cur,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   output logic [TAG_W-1:0] rd_tag,
   output logic [U_W-1:0]   rd_u
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [CTR_W-1:0] ctr_mem [DEPTH];
   logic [TAG_W-1:0] tag_mem [DEPTH];
   logic [U_W-1:0]   u_mem   [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ctr_mem[i] <= '0;
            tag_mem[i] <= '0;
            u_mem[i]   <= '0;
         end
      end else begin
         if (u_we) u_mem[wr_idx] <= u_wdata;
         if (a_we) begin
            tag_mem[wr_idx] <= a_tag;
            ctr_mem[wr_idx] <= a_ctr;
         end
      end
   end

   assign u_cur  = u_mem[wr_idx];
   assign rd_ctr = ctr_mem[rd_idx];
   assign rd_tag = tag_mem[rd_idx];
   assign rd_u   = u_mem[rd_idx];
endmodule

// File: rtl/tage_alloc_sel.sv
module tage_alloc_sel #(
   parameter int unsigned NUM_TABLES = 12,
   parameter int unsigned U_W        = 2,
   parameter int unsigned PROV_W     = 4
) (
   input  logic [PROV_W-1:0]         provider,
   input  logic                      req,
   input  logic [NUM_TABLES*U_W-1:0] u_flat,
   output logic [NUM_TABLES-1:0]     gnt,
   output logic [U_W-1:0]            min_u
);
   logic           found;
   logic [U_W-1:0] u_t;

   // Scan from the longest history toward the provider.
   always_comb begin
      gnt   = '0;
      min_u = U_W'(1);
      found = 1'b0;
      u_t   = '0;
      for (int t = NUM_TABLES - 1; t >= 0; t--) begin
         if (t + 1 > int'(provider)) begin
            u_t = u_flat[t*U_W +: U_W];
            if (u_t < min_u) min_u = u_t;
            if (req && !found && (u_t == '0)) begin
               gnt[t] = 1'b1;
               found  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tage_upd_unit.sv
module tage_upd_unit
   import tage_upd_pkg::*;
#(
   parameter int unsigned NUM_TABLES = 12,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned TAG_W      = 8,
   parameter int unsigned CTR_W      = 3,
   parameter int unsigned U_W        = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                upd_valid,
   input  logic                                upd_taken,
   input  logic [$clog2(NUM_TABLES+1)-1:0]     upd_provider,
   input  logic                                upd_prov_pred,
   input  logic                                upd_alt_pred,
   input  logic                                upd_alloc,
   input  logic [NUM_TABLES*IDX_W-1:0]         upd_idx,
   input  logic [NUM_TABLES*TAG_W-1:0]         upd_tag,
   output logic [U_W-1:0]                      min_u,
   input  logic [$clog2(NUM_TABLES+1)-1:0]     rd_table,
   input  logic [IDX_W-1:0]                    rd_idx,
   output logic [CTR_W-1:0]                    rd_ctr,
   output logic [TAG_W-1:0]                    rd_tag,
   output logic [U_W-1:0]                      rd_u
);
   localparam int unsigned PROV_W = $clog2(NUM_TABLES + 1);

   // Elaboration-time parameter checks.
   generate
      if (U_W < 1 || U_W > U_W_MAX) begin : g_bad_u_w
         $error("usefulness width must be 1 or 2");
      end
      if (CTR_W < 2 || CTR_W > CTR_W_MAX) begin : g_bad_ctr_w
         $error("direction counter width out of range");
      end
      if (NUM_TABLES < 1) begin : g_bad_tables
         $error("at least one tagged table is required");
      end
      if (IDX_W < 1 || TAG_W < 1) begin : g_bad_geom
         $error("index and tag widths must be non-zero");
      end
   endgenerate

   logic [NUM_TABLES*U_W-1:0] u_cur_flat;
   logic [NUM_TABLES-1:0]     u_we;
   logic [NUM_TABLES-1:0]     alloc_gnt;
   logic [U_W-1:0]            u_cur_prov;
   logic [U_W-1:0]            u_wdata;
   logic                      disagree;
   logic                      u_up;
   logic                      alloc_req;
   logic [CTR_W_MAX-1:0]      seed_full;
   logic [CTR_W-1:0]          seed_ctr;

   logic [CTR_W-1:0] bk_ctr [NUM_TABLES];
   logic [TAG_W-1:0] bk_tag [NUM_TABLES];
   logic [U_W-1:0]   bk_u   [NUM_TABLES];

   assign disagree  = upd_prov_pred ^ upd_alt_pred;
   assign u_up      = (upd_prov_pred == upd_taken);
   assign alloc_req = upd_valid & upd_alloc;
   assign seed_full = weak_seed(upd_taken);
   assign seed_ctr  = seed_full[CTR_W-1:0];

   // Provider's current usefulness.
   always_comb begin
      u_cur_prov = '0;
      for (int t = 0; t < NUM_TABLES; t++) begin
         if (int'(upd_provider) == t + 1) u_cur_prov = u_cur_flat[t*U_W +: U_W];
      end
   end

   tage_u_ctr #(.U_W(U_W)) i_u_ctr (
      .cur (u_cur_prov),
      .up  (u_up),
      .nxt (u_wdata)
   );

   tage_alloc_sel #(
      .NUM_TABLES (NUM_TABLES),
      .U_W        (U_W),
      .PROV_W     (PROV_W)
   ) i_alloc_sel (
      .provider (upd_provider),
      .req      (alloc_req),
      .u_flat   (u_cur_flat),
      .gnt      (alloc_gnt),
      .min_u    (min_u)
   );

   generate
      for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
         assign u_we[t] = upd_valid & disagree & (int'(upd_provider) == t + 1);

         tage_bank #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .CTR_W (CTR_W),
            .U_W   (U_W)
         ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_idx  (upd_idx[t*IDX_W +: IDX_W]),
            .u_we    (u_we[t]),
            .u_wdata (u_wdata),
            .a_we    (alloc_gnt[t]),
            .a_tag   (upd_tag[t*TAG_W +: TAG_W]),
            .a_ctr   (seed_ctr),
            .u_cur   (u_cur_flat[t*U_W +: U_W]),
            .rd_idx  (rd_idx),
            .rd_ctr  (bk_ctr[t]),
            .rd_tag  (bk_tag[t]),
            .rd_u    (bk_u[t])
         );
      end
   endgenerate

   // Read port mux; out-of-range table numbers read as zero.
   always_comb begin
      rd_ctr = '0;
      rd_tag = '0;
      rd_u   = '0;
      for (int t = 0; t < NUM_TABLES; t++) begin
         if (int'(rd_table) == t + 1) begin
            rd_ctr = bk_ctr[t];
            rd_tag = bk_tag[t];
            rd_u   = bk_u[t];
         end
      end
   end
endmodule

// File: rtl/tage_upd_chk.sv
module tage_upd_chk #(
   parameter int unsigned NUM_TABLES = 12,
   parameter int unsigned U_W        = 2
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                upd_valid,
   input logic                                upd_taken,
   input logic [$clog2(NUM_TABLES+1)-1:0]     upd_provider,
   input logic                                upd_prov_pred,
   input logic                                upd_alt_pred,
   input logic                                upd_alloc,
   input logic [NUM_TABLES-1:0]               u_we,
   input logic [U_W-1:0]                      u_wdata,
   input logic [U_W-1:0]                      u_cur_prov,
   input logic [NUM_TABLES-1:0]               alloc_gnt,
   input logic [NUM_TABLES*U_W-1:0]           u_cur_flat,
   input logic [U_W-1:0]                      min_u
);
   localparam logic [U_W-1:0] U_TOP = {U_W{1'b1}};

   p_hold_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_prov_pred == upd_alt_pred) |-> (u_we == '0));

   p_no_provider_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_provider == '0 || !upd_valid) |-> (u_we == '0));

   p_single_u_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(u_we));

   p_up_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((u_we != '0) && (upd_prov_pred == upd_taken) && (u_cur_prov == U_TOP))
      |-> (u_wdata == U_TOP));

   p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((u_we != '0) && (upd_prov_pred == upd_taken) && (u_cur_prov != U_TOP))
      |-> (u_wdata == u_cur_prov + U_W'(1)));

   p_down_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((u_we != '0) && (upd_prov_pred != upd_taken) && (u_cur_prov == '0))
      |-> (u_wdata == '0));

   p_single_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_gnt));

   p_no_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && upd_alloc) |-> (alloc_gnt == '0));

   p_min_capped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (min_u <= U_W'(1)));

   generate
      for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl_chk
         p_longer_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[t] |-> (int'(upd_provider) < t + 1));

         p_free_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[t] |-> (u_cur_flat[t*U_W +: U_W] == '0));

         p_min_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[t] |-> (min_u == '0));
      end
   endgenerate
endmodule

bind tage_upd_unit tage_upd_chk #(
   .NUM_TABLES (NUM_TABLES),
   .U_W        (U_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .upd_valid     (upd_valid),
   .upd_taken     (upd_taken),
   .upd_provider  (upd_provider),
   .upd_prov_pred (upd_prov_pred),
   .upd_alt_pred  (upd_alt_pred),
   .upd_alloc     (upd_alloc),
   .u_we          (u_we),
   .u_wdata       (u_wdata),
   .u_cur_prov    (u_cur_prov),
   .alloc_gnt     (alloc_gnt),
   .u_cur_flat    (u_cur_flat),
   .min_u         (min_u)
);

// File: tb/test_tage_upd_unit.sv
`timescale 1ns/1ps
module test_tage_upd_unit;
   localparam int NT = 12;
   localparam int IW = 4;
   localparam int TW = 8;
   localparam int CW = 3;
   localparam int UW = 2;
   localparam int PW = $clog2(NT + 1);
   localparam int DEPTH = 1 << IW;
   localparam int UMAX = (1 << UW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              upd_valid = 1'b0;
   logic              upd_taken = 1'b0;
   logic [PW-1:0]     upd_provider = '0;
   logic              upd_prov_pred = 1'b0;
   logic              upd_alt_pred = 1'b0;
   logic              upd_alloc = 1'b0;
   logic [NT*IW-1:0]  upd_idx = '0;
   logic [NT*TW-1:0]  upd_tag = '0;
   logic [UW-1:0]     min_u;
   logic [PW-1:0]     rd_table = '0;
   logic [IW-1:0]     rd_idx = '0;
   logic [CW-1:0]     rd_ctr;
   logic [TW-1:0]     rd_tag;
   logic [UW-1:0]     rd_u;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Reference state, table 0 unused.
   int m_ctr [NT+1][DEPTH];
   int m_tag [NT+1][DEPTH];
   int m_u   [NT+1][DEPTH];
   int b_idx [NT+1];
   int b_tag [NT+1];

   always #2 clk = ~clk;

   tage_upd_unit #(
      .NUM_TABLES (NT), .IDX_W (IW), .TAG_W (TW), .CTR_W (CW), .U_W (UW)
   ) i_tage_upd_unit (
      .clk (clk), .rst_n (rst_n), .upd_valid (upd_valid), .upd_taken (upd_taken),
      .upd_provider (upd_provider), .upd_prov_pred (upd_prov_pred),
      .upd_alt_pred (upd_alt_pred), .upd_alloc (upd_alloc), .upd_idx (upd_idx),
      .upd_tag (upd_tag), .min_u (min_u), .rd_table (rd_table), .rd_idx (rd_idx),
      .rd_ctr (rd_ctr), .rd_tag (rd_tag), .rd_u (rd_u)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int pack_entry(input int c, input int tg, input int u);
      return (c << 16) | (tg << 4) | u;
   endfunction

   task automatic chk_entry(input int t, input int i, input string req);
      int act;
      int exp;
      rd_table = PW'(t);
      rd_idx   = IW'(i);
      #1;
      act = pack_entry(int'(rd_ctr), int'(rd_tag), int'(rd_u));
      if (t >= 1 && t <= NT) exp = pack_entry(m_ctr[t][i], m_tag[t][i], m_u[t][i]);
      else                   exp = 0;
      check(act == exp, req, $sformatf("entry t%0d i%0d", t, i), act, exp);
   endtask

   // One update request; checks min_u before the edge, every table after it.
   task automatic do_op(input int prov, input bit pp, input bit ap, input bit tk,
                        input bit al, input string lbl);
      int    exp_min;
      string l;
      @(negedge clk);
      upd_valid     = 1'b1;
      upd_provider  = PW'(prov);
      upd_prov_pred = pp;
      upd_alt_pred  = ap;
      upd_taken     = tk;
      upd_alloc     = al;
      for (int t = 1; t <= NT; t++) begin
         upd_idx[(t-1)*IW +: IW] = IW'(b_idx[t]);
         upd_tag[(t-1)*TW +: TW] = TW'(b_tag[t]);
      end
      exp_min = 1;
      for (int t = NT; t > prov; t--)
         if (m_u[t][b_idx[t]] < exp_min) exp_min = m_u[t][b_idx[t]];
      #1;
      check(int'(min_u) == exp_min, "R9", "min_u", int'(min_u), exp_min);
      // Reference update from the pre-edge state.
      if (prov != 0 && pp != ap) begin
         if (pp == tk) begin
            if (m_u[prov][b_idx[prov]] < UMAX) m_u[prov][b_idx[prov]]++;
         end else begin
            if (m_u[prov][b_idx[prov]] > 0) m_u[prov][b_idx[prov]]--;
         end
      end
      if (al) begin
         for (int t = NT; t > prov; t--) begin
            if (m_u[t][b_idx[t]] == 0) begin
               m_tag[t][b_idx[t]] = b_tag[t];
               m_ctr[t][b_idx[t]] = tk ? 0 : (1 << CW) - 1;
               break;
            end
         end
      end
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      upd_alloc = 1'b0;
      if (lbl != "") l = lbl;
      else if (al) l = "R7";
      else if (prov != 0 && pp != ap) l = (pp == tk) ? "R3" : "R4";
      else l = "R2";
      for (int t = 1; t <= NT; t++) chk_entry(t, b_idx[t], l);
   endtask

   task automatic set_all_idx(input int i);
      for (int t = 1; t <= NT; t++) begin
         b_idx[t] = i;
         b_tag[t] = (t * 16 + 5) & 8'hFF;
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int t = 0; t <= NT; t++)
         for (int i = 0; i < DEPTH; i++) begin
            m_ctr[t][i] = 0;
            m_tag[t][i] = 0;
            m_u[t][i]   = 0;
         end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset contents
      for (int t = 1; t <= NT; t++)
         for (int i = 0; i < DEPTH; i += 5) chk_entry(t, i, "R1");

      set_all_idx(5);
      do_op(12, 1, 0, 1, 0, "R3");         // table 12 usefulness 0 -> 1
      do_op(0, 0, 0, 0, 1, "R6");          // table 12 busy: table 11 claimed, ctr -1
      do_op(0, 1, 1, 1, 1, "R7");          // table 11 still free: re-claimed, ctr 0
      do_op(12, 1, 0, 1, 0, "R3");
      do_op(12, 1, 0, 1, 0, "R3");
      do_op(12, 1, 0, 1, 0, "R3");         // saturates at 3
      do_op(12, 1, 1, 0, 0, "R2");         // agree: held
      do_op(0, 1, 0, 0, 0, "R2");          // no provider: held
      for (int k = 0; k < 4; k++) do_op(12, 0, 1, 1, 0, "R4"); // down to 0 and stays
      do_op(12, 1, 0, 1, 1, "R5");         // no candidates, min_u 1
      do_op(11, 1, 0, 1, 0, "R3");
      do_op(12, 1, 0, 1, 0, "R3");
      do_op(10, 1, 0, 0, 1, "R8");         // tables 11,12 busy: nothing claimed
      do_op(3, 0, 1, 1, 1, "R5");          // table 10 claimed, 4..9 untouched
      set_all_idx(9);
      do_op(4, 1, 0, 1, 0, "R8");          // alloc low: no tag change

      // Constrained random traffic with index collisions.
      for (int n = 0; n < 300; n++) begin
         for (int t = 1; t <= NT; t++) begin
            b_idx[t] = $urandom % 4;
            b_tag[t] = $urandom % 256;
         end
         do_op($urandom % (NT + 1), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 3) == 0, "");
      end

      // R10: read port, full scan and out-of-range table numbers.
      for (int t = 1; t <= NT; t++)
         for (int i = 0; i < DEPTH; i++) chk_entry(t, i, "R10");
      chk_entry(0, 1, "R10");
      chk_entry(NT + 1, 2, "R10");
      chk_entry(15, 0, "R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule